// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs the management side of a two-wire PHY management bus that uses clause-22 frames. A client gives it one request at a time: read or write, a 5-bit PHY address, a 5-bit register address and, for a write, a 16-bit value. The master turns the request into a serial frame. It produces the management clock from a programmable half-period divider, drives the data line through an output-enable so the line can be tristated, and collects the reply of a read.

Every frame starts with a run of preamble ones. A write sends its complete command and data word. A read sends only the header and then releases the line for the turnaround. After the turnaround clock the PHY either pulls the line low to acknowledge or leaves it high. The 16 data bits follow, and one last tristate clock ends the transaction. The client sees a single-cycle completion pulse, together with the read value and a flag that reports a missing acknowledge. A read that is not acknowledged returns all ones.

Top module: `mdio_master`

## Requirements
- R1: While reset is held, `mdc`, `mdio_oe`, `mdio_o`, `done` and `busy` are all low.
- R2: A write frame is 32 preamble ones followed by the 32-bit word {start 01, opcode 01, PHY address, register address, turnaround 10, write data}. It is sent MSB first, with each bit valid while `mdc` rises.
- R3: A read frame is 32 preamble ones followed by the 14 bits {start 01, opcode 10, PHY address, register address}, MSB first. After these the master drives no more bits.
- R4: Every clock bit is a low phase followed by a high phase. Each phase lasts HALF_DIV cycles of `clk`, and a driven data bit does not change while `mdc` is high.
- R5: `mdio_oe` is high only while frame bits are being driven, plus one trailing low phase after the last driven bit. It falls only while `mdc` is low. `mdio_o` is low whenever `mdio_oe` is low.
- R6: On a read, `mdio_i` is sampled at the end of the turnaround clock's high phase, and a low level counts as the acknowledge. The 16 data bits are then sampled MSB first, each at the end of a high phase. With an acknowledge, `rd_data` returns the captured word.
- R7: A read without an acknowledge gives `rd_data` = 0xFFFF and `ack_err` = 1, whatever bits were captured. A write always completes with `ack_err` = 0.
- R8: `done` is a pulse one cycle long. It goes high 131×HALF_DIV cycles after the accepting edge for a write, or 129×HALF_DIV cycles for a read.
- R9: A request is accepted only while `busy` is low. A request raised while busy neither changes the frame in progress nor starts another one.
- R10: Each frame ends with one tristate clock. A write has 65 rising edges of `mdc` (64 driven, 1 tristate). A read has 64 (46 driven, 1 turnaround, 16 data, 1 final).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with `done` |
| ack_err | output | 1 | Read saw no acknowledge, valid with `done` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for the data line |
| mdio_i | input | 1 | Management data in (line level) |

## Verification
The assertions assume that `mdio_i` is synchronous to `clk` and has settled before the edge that ends a high phase. They also assume that request fields only matter on the accepting edge. The bench's PHY model follows the data line and changes `mdio_i` only on falling edges of `clk`, well inside each phase. It sees a pulled-up line whenever no device drives it. The driver raises `req` only on falling edges, and raises it while busy only on purpose, to show that such a request is ignored.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    // clause-22 field widths
    localparam int PHY_W    = 5;
    localparam int REG_W    = 5;
    localparam int DATA_W   = 16;

    // frame codes
    localparam logic [1:0] SOF      = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] TA_DRIVE = 2'b10;

    // header = start + opcode + addresses
    localparam int HDR_W    = 4 + PHY_W + REG_W;
    localparam int WR_CMD_W = HDR_W + 2 + DATA_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_TAIL,
        ST_TURN,
        ST_RECV,
        ST_FINAL,
        ST_DONE
    } mstate_e;

    typedef struct packed {
        logic              wr;
        logic [PHY_W-1:0]  phy;
        logic [REG_W-1:0]  regad;
        logic [DATA_W-1:0] wdata;
    } mreq_t;

    // Command word, left aligned; a read keeps only its header bits.
    function automatic logic [WR_CMD_W-1:0] cmd_word(input mreq_t r);
        if (r.wr)
            return {SOF, OP_WRITE, r.phy, r.regad, TA_DRIVE, r.wdata};
        else
            return {SOF, OP_READ, r.phy, r.regad, {(2 + DATA_W){1'b0}}};
    endfunction

endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mdio_tx_shifter.sv
module mdio_tx_shifter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         advance,
    output logic         bit_o
);
    logic [W-1:0] sh;

    assign bit_o = sh[W-1];

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else if (load)
            sh <= load_val;
        else if (advance)
            sh <= {sh[W-2:0], 1'b0};
    end
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         ack_stb,
    input  logic         bit_stb,
    input  logic         sdi,
    output logic         ack_ok,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ack_ok <= 1'b0;
            word   <= '0;
        end else begin
            if (ack_stb)
                ack_ok <= !sdi;
            if (bit_stb)
                word <= {word[W-2:0], sdi};
        end
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int PRE_BITS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_write,
    input  logic [PHY_W-1:0]  req_phy,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              ack_err,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int FRAME_W = PRE_BITS + WR_CMD_W;
    localparam int RD_BITS = PRE_BITS + HDR_W;
    localparam int BCW     = $clog2(FRAME_W + 1);
    localparam logic [BCW-1:0] WR_LAST = BCW'(FRAME_W - 1);
    localparam logic [BCW-1:0] RD_LAST = BCW'(RD_BITS - 1);
    localparam logic [BCW-1:0] RX_LAST = BCW'(DATA_W - 1);

    mstate_e            state;
    logic               hi;
    logic               wr_q;
    logic [BCW-1:0]     bit_idx;
    logic [BCW-1:0]     last_idx;
    logic               tick;
    logic               timer_en;
    logic               accept;
    logic               tx_shift;
    logic               tx_bit;
    logic               ack_stb;
    logic               bit_stb;
    logic               ack_ok;
    logic [DATA_W-1:0]  rx_word;
    mreq_t              req_s;
    logic [FRAME_W-1:0] frame_img;

    assign req_s     = '{wr: req_write, phy: req_phy, regad: req_reg, wdata: req_wdata};
    assign frame_img = {{PRE_BITS{1'b1}}, cmd_word(req_s)};
    assign accept    = req && (state == ST_IDLE);
    assign timer_en  = (state != ST_IDLE) && (state != ST_DONE);
    assign tx_shift  = tick && hi && (state == ST_SEND) && (bit_idx != last_idx);
    assign ack_stb   = tick && hi && (state == ST_TURN) && !wr_q;
    assign bit_stb   = tick && hi && (state == ST_RECV);

    mdio_phase_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .en   (timer_en),
        .tick (tick)
    );

    mdio_tx_shifter #(.W(FRAME_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (frame_img),
        .advance  (tx_shift),
        .bit_o    (tx_bit)
    );

    mdio_rx_capture #(.W(DATA_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .ack_stb (ack_stb),
        .bit_stb (bit_stb),
        .sdi     (mdio_i),
        .ack_ok  (ack_ok),
        .word    (rx_word)
    );

    // Phase walker: every clocked state is a low phase then a high phase.
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            hi       <= 1'b0;
            wr_q     <= 1'b0;
            bit_idx  <= '0;
            last_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state    <= ST_SEND;
                        hi       <= 1'b0;
                        wr_q     <= req_write;
                        bit_idx  <= '0;
                        last_idx <= req_write ? WR_LAST : RD_LAST;
                    end
                end
                ST_SEND: begin
                    if (tick) begin
                        if (!hi) begin
                            hi <= 1'b1;
                        end else begin
                            hi <= 1'b0;
                            if (bit_idx == last_idx)
                                state <= ST_TAIL;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick)
                        state <= ST_TURN;
                end
                ST_TURN: begin
                    if (tick) begin
                        if (!hi) begin
                            hi <= 1'b1;
                        end else begin
                            hi      <= 1'b0;
                            bit_idx <= '0;
                            state   <= wr_q ? ST_DONE : ST_RECV;
                        end
                    end
                end
                ST_RECV: begin
                    if (tick) begin
                        if (!hi) begin
                            hi <= 1'b1;
                        end else begin
                            hi <= 1'b0;
                            if (bit_idx == RX_LAST)
                                state <= ST_FINAL;
                            else
                                bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                ST_FINAL: begin
                    if (tick) begin
                        if (!hi) begin
                            hi <= 1'b1;
                        end else begin
                            hi    <= 1'b0;
                            state <= ST_DONE;
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_DONE);
    assign mdc     = hi;
    assign mdio_oe = (state == ST_SEND) || (state == ST_TAIL);
    assign mdio_o  = mdio_oe && tx_bit;
    assign rd_data = ack_ok ? rx_word : '1;
    assign ack_err = done && !wr_q && !ack_ok;
endmodule

// File: rtl/mdio_master_checker.sv
module mdio_master_checker (
    input logic        clk,
    input logic        rst,
    input logic        req,
    input logic        busy,
    input logic        done,
    input logic [15:0] rd_data,
    input logic        ack_err,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe && !mdio_o));

    assert_release_low_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(mdio_oe) |-> !mdc);

    assert_bit_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe && mdc) |-> $stable(mdio_o));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_noack_ones_R7: assert property (@(posedge clk) disable iff (rst)
        (done && ack_err) |-> (rd_data == 16'hFFFF));

    assert_start_on_req_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req));

    assert_hold_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
endmodule

bind mdio_master mdio_master_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .busy    (busy),
    .done    (done),
    .rd_data (rd_data),
    .ack_err (ack_err),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int DIV = 3;
    localparam logic [4:0] RESP_PHY = 5'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, ack_err, mdc, mdio_o, mdio_oe, mdio_i;
    logic [15:0] rd_data;

    always #5 clk = ~clk;

    mdio_master #(.HALF_DIV(DIV), .PRE_BITS(32)) dut (
        .clk(clk), .rst(rst), .req(req), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .ack_err(ack_err),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    typedef struct {
        bit          wr;
        logic [15:0] rd;
        bit          err;
        int          cyc;
        logic [63:0] frame;
        logic [63:0] mask;
        int          nbits;
        int          rises;
    } exp_t;

    exp_t q[$];
    int   nchk = 0;
    int   nfail = 0;
    int   cyc = 0;

    // PHY model state
    logic [63:0] cap = '0;
    int          ncap = 0;
    int          nrise = 0;
    bit          rsp_active = 0;
    int          rsp_cnt = 0;
    logic [15:0] rsp_word = '0;
    logic        prev_mdc = 1'b0;
    int          hrun = 0;

    function automatic logic [15:0] phy_word(input logic [4:0] r);
        return 16'hC35A ^ {r, r, r, 1'b1};
    endfunction

    assign mdio_i = mdio_oe ? mdio_o :
                    (rsp_active && rsp_cnt == 1) ? 1'b0 :
                    (rsp_active && rsp_cnt >= 2 && rsp_cnt <= 17) ? rsp_word[17 - rsp_cnt] :
                    1'b1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // PHY model + scoreboard monitor
    always @(negedge clk) begin
        if (rst) begin
            prev_mdc = 1'b0;
            hrun     = 0;
        end else begin
            if (mdc && !prev_mdc) begin
                nrise++;
                if (mdio_oe) begin
                    cap = {cap[62:0], mdio_o};
                    ncap++;
                    if (ncap == 46 && cap[13:10] == 4'b0110 && cap[9:5] == RESP_PHY) begin
                        rsp_active = 1;
                        rsp_cnt    = 0;
                        rsp_word   = phy_word(cap[4:0]);
                    end
                end else if (rsp_active) begin
                    rsp_cnt++;
                end
            end
            if (mdc) begin
                hrun++;
            end else if (hrun != 0) begin
                chk(hrun == DIV, "R4 high phase length", 64'(hrun), 64'(DIV));
                hrun = 0;
            end
            prev_mdc = mdc;

            if (done) begin
                if (q.size() == 0) begin
                    chk(0, "R9 unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (!e.wr)
                        chk(rd_data == e.rd, "R6/R7 read data", 64'(rd_data), 64'(e.rd));
                    chk(ack_err == e.err, "R7 ack_err", 64'(ack_err), 64'(e.err));
                    chk(cyc == e.cyc, "R8 done latency", 64'(cyc), 64'(e.cyc));
                    chk((cap & e.mask) == e.frame, e.wr ? "R2 write frame" : "R3 read frame",
                        cap & e.mask, e.frame);
                    chk(ncap == e.nbits, "R3 driven bit count", 64'(ncap), 64'(e.nbits));
                    chk(nrise == e.rises, "R10 mdc rises", 64'(nrise), 64'(e.rises));
                end
                cap        = '0;
                ncap       = 0;
                nrise      = 0;
                rsp_active = 0;
                rsp_cnt    = 0;
            end
        end
    end

    task automatic issue(input bit wr, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        e.wr = wr;
        e.err = !wr && (phy != RESP_PHY);
        e.rd = (!wr && phy == RESP_PHY) ? phy_word(rg) : 16'hFFFF;
        e.cyc = cyc + 1 + (wr ? 131 : 129) * DIV;
        if (wr) begin
            e.frame = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, wd};
            e.mask  = '1;
            e.nbits = 64;
            e.rises = 65;
        end else begin
            e.frame = {18'b0, 32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg};
            e.mask  = 64'h0000_3FFF_FFFF_FFFF;
            e.nbits = 46;
            e.rises = 64;
        end
        q.push_back(e);
        req = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic stray_pulse();
        @(negedge clk);
        req = 1'b1; req_write = 1'b0; req_phy = RESP_PHY; req_reg = 5'h0A; req_wdata = 16'h0F0F;
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(!mdc && !mdio_oe && !mdio_o, "R1 bus quiet in reset", {mdc, mdio_oe, mdio_o}, 0);
        chk(!done && !busy, "R1 status quiet in reset", {done, busy}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy && !mdio_oe, "R5 idle after reset", {busy, mdio_oe}, 0);

        issue(1'b1, RESP_PHY, 5'h00, 16'h1234);          // R2
        issue(1'b0, RESP_PHY, 5'h02, 16'h0000);          // R3 R6
        issue(1'b0, RESP_PHY, 5'h1F, 16'h0000);          // R6 back to back
        issue(1'b1, RESP_PHY, 5'h1F, 16'hFFFF);          // R2 all-ones data
        issue(1'b1, 5'h1F, 5'h00, 16'h0000);             // R2 all-zero data
        issue(1'b0, 5'h07, 5'h04, 16'h0000);             // R7 no ack
        issue(1'b0, 5'h00, 5'h00, 16'h0000);             // R7 no ack, zero fields
        issue(1'b0, RESP_PHY, 5'h15, 16'h0000);          // R6

        // R9: request during a busy frame is ignored
        issue(1'b1, RESP_PHY, 5'h11, 16'hBEEF);
        repeat (20) @(negedge clk);
        stray_pulse();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(!busy && !mdc && !mdio_oe, "R9 no second frame", {busy, mdc, mdio_oe}, 0);

        while (q.size() != 0 || busy) @(negedge clk);
        chk(!mdio_oe && !mdio_o, "R5 released at end", {mdio_oe, mdio_o}, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule